// File: doc/BRIEF.md
# Answer-to-Reset Parser

After a reset, a smart card sends a short answer that describes itself. This block takes that answer one byte at a time and splits it into its fields. The fields are the initial character, the format byte, up to four groups of interface bytes, the historical bytes and an optional trailing check byte. Each byte arrives with a valid strobe and a set of receive-error flags. Bytes with any error flag raised are dropped before they reach the parser.

The walk is driven by presence nibbles. The format byte's high nibble selects which of the four interface letters (A, B, C, D) appear in the first group. The high nibble of each D byte selects the letters of the next group. Interface bytes land in a 16-slot array with a presence mask, and historical bytes land in their own array. Every accepted byte is also appended to a bounded raw log. When the answer is complete, a one-cycle done pulse marks that the decoded communication parameters are valid. These are the clock-rate index, the baud divisor index, the extra guard time, the protocol type and the work wait time. A synchronous restart input prepares the parser for the next answer.

States:
- `ST_INIT`: waiting for the initial character.
- `ST_FMT`: waiting for the format byte.
- `ST_IFC`: walking interface groups.
- `ST_HIST`: collecting historical bytes.
- `ST_CHK`: waiting for the check byte.
- `ST_DONE`: complete.
- `ST_FAULT`: too many groups.

Transitions:
- INIT→FMT on any accepted byte.
- FMT→IFC when the presence nibble is non-zero. Otherwise FMT→HIST/CHK/DONE through the exit rule.
- IFC→IFC while letters remain or a D byte chains a non-zero nibble.
- IFC→exit rule when a group ends with no D byte, or with a zero nibble in its D byte.
- IFC→FAULT when the fourth D byte announces a fifth group.
- HIST→CHK/DONE after the last historical byte.
- CHK→DONE on the check byte.
- Any state→INIT on restart.

The exit rule goes to HIST if the historical count is non-zero. Otherwise it goes to CHK when T=1 was declared, and to DONE in all other cases.

Top module: `atr_parser`

## Requirements
- R1: The first accepted byte is held on `init_char`. The second accepted byte is the format byte: bits [7:4] are the presence set of group 1 (bit 4 = A, 5 = B, 6 = C, 7 = D), and bits [3:0] are the historical byte count.
- R2: Within a group, interface bytes are taken lowest presence bit first (A, B, C, D). Each byte is stored at slot group*4 + letter (A=0, B=1, C=2, D=3; group 0 to 3), packed in `ifc_bytes[slot*8 +: 8]`. The same slot's bit of `ifc_mask` is set.
- R3: A D byte's bits [7:4] become the presence set of the next group.
- R4: When a group ends without a D byte, or a D byte carries a zero presence nibble, parsing moves to the historical bytes. If the historical count is zero, it moves straight to the check-byte decision. A format byte of `0x00` completes at once.
- R5: Historical bytes are stored in arrival order in `hist_bytes[i*8 +: 8]`. `hist_count` reports how many were taken.
- R6: A check byte is awaited only when the group-1 D byte is present and its bits [3:0] equal 1. That byte is then captured on `chk_byte`. Otherwise parsing completes on the last historical or interface byte.
- R7: `done` is high for exactly one cycle, the cycle after the edge that accepted the final byte. Bytes offered after completion change no output.
- R8: After completion the parameter outputs decode as follows:
  - `fi` = slot 0 bits [7:4], default 1
  - `di` = slot 0 bits [3:0], default 1
  - `guard_n` = slot 2, default 0
  - `proto` = slot 3 bits [3:0], default 0
  - `wwt` = slot 6, default 10

  Each default applies when the slot is absent.
- R9: Every accepted byte is appended to the raw log at `raw_bytes[raw_count*8 +: 8]`. When the log already holds RAW_DEPTH bytes, the byte is not written, `raw_count` holds, and `raw_ovf` rises and stays high.
- R10: A byte offered with any `rx_err` bit set is ignored. It is not logged and does not advance the parse.
- R11: A group-4 D byte with a non-zero presence nibble raises `err_groups`. The parser then stops without `done`, and later bytes are ignored.
- R12: A historical count above HIST_MAX is clamped to HIST_MAX and raises `err_hist`.
- R13: Reset or `restart` clears every stored field, the mask, the log and the error flags. The parser returns to waiting for the initial character, and the parameter outputs show their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous clear, back to the initial character |
| rx_valid | input | 1 | Byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_err | input | ERR_W | Receive-error flags for the byte |
| done | output | 1 | One-cycle completion pulse |
| init_char | output | 8 | Initial character |
| ifc_mask | output | 16 | Presence mask of interface slots |
| ifc_bytes | output | 128 | Interface slots, 8 bits each |
| hist_bytes | output | HIST_MAX*8 | Historical bytes |
| hist_count | output | 4 | Historical bytes taken |
| chk_byte | output | 8 | Check byte |
| fi | output | 4 | Clock-rate index |
| di | output | 4 | Baud divisor index |
| guard_n | output | 8 | Extra guard time |
| proto | output | 4 | Declared protocol type |
| wwt | output | 8 | Work wait time |
| raw_bytes | output | RAW_DEPTH*8 | Raw log |
| raw_count | output | clog2(RAW_DEPTH+1) | Bytes in raw log |
| raw_ovf | output | 1 | Raw log overflow |
| err_groups | output | 1 | Fifth group announced |
| err_hist | output | 1 | Historical count clamped |

## Verification
Seeded random answers vary four things:
- the presence nibbles of each group;
- the chain length, from zero to four groups;
- the historical count, including values above the clamp;
- the protocol nibble, which is 0, 1 or 2.

This separates the slot indexing and the chain walk from the check-byte decision. Error-flagged bytes are mixed in at random, so an error byte that leaked into the log or the walk would shift every later field. Answers longer than the raw log separate the overflow behaviour from normal appending.

Directed answers cover further cases:
- a format byte of zero;
- a T=1 answer with no historical bytes;
- a work wait time taken from group 2;
- a chain that announces a fifth group.

Bytes offered after completion show whether the parser truly stops.

// File: rtl/atrp_pkg.sv
package atrp_pkg;
    typedef enum logic [2:0] {
        ST_INIT, ST_FMT, ST_IFC, ST_HIST, ST_CHK, ST_DONE, ST_FAULT
    } atr_state_t;

    localparam int GROUPS  = 4;
    localparam int LETTERS = 4;
    localparam int SLOTS   = GROUPS * LETTERS;
    localparam int BW      = 8;

    localparam logic [3:0] PROTO_BLOCK = 4'd1;
    localparam logic [3:0] DEF_FI      = 4'd1;
    localparam logic [3:0] DEF_DI      = 4'd1;
    localparam logic [7:0] DEF_N       = 8'd0;
    localparam logic [3:0] DEF_T       = 4'd0;
    localparam logic [7:0] DEF_WWT     = 8'd10;

    localparam int SLOT_TA1 = 0;
    localparam int SLOT_TC1 = 2;
    localparam int SLOT_TD1 = 3;
    localparam int SLOT_TC2 = 6;
endpackage

// File: rtl/atr_slot_pick.sv
module atr_slot_pick (
    input  logic [3:0] pres,
    output logic [1:0] letter,
    output logic [3:0] rest
);
    always_comb begin
        letter = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (pres[i]) letter = 2'(i);
        end
        rest = pres & ~(4'b0001 << letter);
    end
endmodule

// File: rtl/atr_param_decode.sv
module atr_param_decode
    import atrp_pkg::*;
(
    input  logic [SLOTS-1:0]    mask,
    input  logic [SLOTS*BW-1:0] slots,
    output logic [3:0]          fi,
    output logic [3:0]          di,
    output logic [7:0]          guard_n,
    output logic [3:0]          proto,
    output logic [7:0]          wwt
);
    logic [7:0] ta1, tc1, td1, tc2;

    assign ta1 = slots[SLOT_TA1*BW +: BW];
    assign tc1 = slots[SLOT_TC1*BW +: BW];
    assign td1 = slots[SLOT_TD1*BW +: BW];
    assign tc2 = slots[SLOT_TC2*BW +: BW];

    always_comb begin
        fi      = mask[SLOT_TA1] ? ta1[7:4] : DEF_FI;
        di      = mask[SLOT_TA1] ? ta1[3:0] : DEF_DI;
        guard_n = mask[SLOT_TC1] ? tc1      : DEF_N;
        proto   = mask[SLOT_TD1] ? td1[3:0] : DEF_T;
        wwt     = mask[SLOT_TC2] ? tc2      : DEF_WWT;
    end
endmodule

// File: rtl/atr_raw_log.sv
module atr_raw_log #(
    parameter  int DEPTH = 33,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [7:0]        din,
    output logic [DEPTH*8-1:0] mem_flat,
    output logic [CW-1:0]     cnt,
    output logic              ovf
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [DEPTH-1:0][7:0] mem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clr) begin
            mem <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else if (wr) begin
            if (cnt == FULL) begin
                ovf <= 1'b1;
            end else begin
                mem[cnt[IW-1:0]] <= din;
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign mem_flat = mem;

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && cnt == FULL) |=> (ovf && $stable(cnt)));
endmodule

// File: rtl/atr_parser.sv
module atr_parser
    import atrp_pkg::*;
#(
    parameter  int HIST_MAX  = 15,
    parameter  int RAW_DEPTH = 33,
    parameter  int ERR_W     = 3,
    localparam int RCW       = $clog2(RAW_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    input  logic [ERR_W-1:0]        rx_err,
    output logic                    done,
    output logic [7:0]              init_char,
    output logic [15:0]             ifc_mask,
    output logic [127:0]            ifc_bytes,
    output logic [HIST_MAX*8-1:0]   hist_bytes,
    output logic [3:0]              hist_count,
    output logic [7:0]              chk_byte,
    output logic [3:0]              fi,
    output logic [3:0]              di,
    output logic [7:0]              guard_n,
    output logic [3:0]              proto,
    output logic [7:0]              wwt,
    output logic [RAW_DEPTH*8-1:0]  raw_bytes,
    output logic [RCW-1:0]          raw_count,
    output logic                    raw_ovf,
    output logic                    err_groups,
    output logic                    err_hist
);
    localparam logic [3:0] HMAX4 = 4'(HIST_MAX);

    atr_state_t state, state_nx;
    logic [3:0] pres, pres_nx, rest;
    logic [1:0] grp, grp_nx, letter;
    logic       t1_seen, t1_nx;
    logic [3:0] hist_tgt, hcnt, hclamp;
    logic       take;
    logic [SLOTS-1:0][7:0]  ifc_arr;
    logic [HIST_MAX-1:0][7:0] hist_arr;

    assign take = rx_valid && (rx_err == '0) &&
                  (state != ST_DONE) && (state != ST_FAULT);
    assign hclamp = (rx_byte[3:0] > HMAX4) ? HMAX4 : rx_byte[3:0];

    atr_slot_pick u_pick (.pres(pres), .letter(letter), .rest(rest));

    function automatic atr_state_t after_ifc(input logic [3:0] tgt, input logic t1);
        if (tgt != 4'd0)  return ST_HIST;
        else if (t1)      return ST_CHK;
        else              return ST_DONE;
    endfunction

    // next-state logic
    always_comb begin
        state_nx = state;
        pres_nx  = pres;
        grp_nx   = grp;
        t1_nx    = t1_seen;
        unique case (state)
            ST_INIT: if (take) state_nx = ST_FMT;
            ST_FMT: if (take) begin
                pres_nx = rx_byte[7:4];
                grp_nx  = 2'd0;
                state_nx = (rx_byte[7:4] != 4'd0) ? ST_IFC : after_ifc(hclamp, 1'b0);
            end
            ST_IFC: if (take) begin
                pres_nx = rest;
                if (letter == 2'd3) begin
                    pres_nx = rx_byte[7:4];
                    grp_nx  = grp + 2'd1;
                    if (grp == 2'd0) t1_nx = (rx_byte[3:0] == PROTO_BLOCK);
                end
                if (letter == 2'd3 && grp == 2'd3 && rx_byte[7:4] != 4'd0)
                    state_nx = ST_FAULT;
                else if (pres_nx == 4'd0)
                    state_nx = after_ifc(hist_tgt, t1_nx);
            end
            ST_HIST: if (take && (4'(hcnt + 4'd1) == hist_tgt))
                state_nx = t1_seen ? ST_CHK : ST_DONE;
            ST_CHK: if (take) state_nx = ST_DONE;
            ST_DONE, ST_FAULT: state_nx = state;
            default: state_nx = ST_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_INIT; pres <= '0; grp <= '0; t1_seen <= 1'b0;
        end else if (restart) begin
            state <= ST_INIT; pres <= '0; grp <= '0; t1_seen <= 1'b0;
        end else begin
            state <= state_nx; pres <= pres_nx; grp <= grp_nx; t1_seen <= t1_nx;
        end
    end

    // captured fields and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0; init_char <= '0; ifc_mask <= '0; ifc_arr <= '0;
            hist_arr <= '0; hist_tgt <= '0; hcnt <= '0; chk_byte <= '0;
            err_groups <= 1'b0; err_hist <= 1'b0;
        end else if (restart) begin
            done <= 1'b0; init_char <= '0; ifc_mask <= '0; ifc_arr <= '0;
            hist_arr <= '0; hist_tgt <= '0; hcnt <= '0; chk_byte <= '0;
            err_groups <= 1'b0; err_hist <= 1'b0;
        end else begin
            done <= (state_nx == ST_DONE) && (state != ST_DONE);
            if (state_nx == ST_FAULT && state != ST_FAULT) err_groups <= 1'b1;
            if (take) begin
                unique case (state)
                    ST_INIT: init_char <= rx_byte;
                    ST_FMT: begin
                        hist_tgt <= hclamp;
                        err_hist <= (rx_byte[3:0] > HMAX4);
                    end
                    ST_IFC: begin
                        ifc_arr[{grp, letter}]  <= rx_byte;
                        ifc_mask[{grp, letter}] <= 1'b1;
                    end
                    ST_HIST: begin
                        hist_arr[hcnt] <= rx_byte;
                        hcnt <= hcnt + 4'd1;
                    end
                    ST_CHK: chk_byte <= rx_byte;
                    ST_DONE, ST_FAULT: ;
                    default: ;
                endcase
            end
        end
    end

    assign ifc_bytes  = ifc_arr;
    assign hist_bytes = hist_arr;
    assign hist_count = hcnt;

    atr_param_decode u_dec (
        .mask(ifc_mask), .slots(ifc_bytes),
        .fi(fi), .di(di), .guard_n(guard_n), .proto(proto), .wwt(wwt)
    );

    atr_raw_log #(.DEPTH(RAW_DEPTH)) u_log (
        .clk(clk), .rst_n(rst_n), .clr(restart), .wr(take), .din(rx_byte),
        .mem_flat(raw_bytes), .cnt(raw_count), .ovf(raw_ovf)
    );

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_err_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_err != '0 && !restart) |=>
        ($stable(state) && $stable(ifc_mask) && $stable(hcnt)));
    assert_mask_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> ((ifc_mask & $past(ifc_mask)) == $past(ifc_mask)));
    assert_restart_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state == ST_INIT && ifc_mask == '0 && !done && raw_count == '0));
    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && !restart) |=> (state == ST_FAULT && !done));
    assert_hist_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt <= hist_tgt && hist_tgt <= HMAX4));
endmodule

// File: tb/atr_parser_test.sv
module atr_parser_test;
    localparam int CLK_P = 10;
    localparam int HMAX  = 10;
    localparam int RDEP  = 20;
    localparam int RCW   = $clog2(RDEP + 1);

    logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [2:0] rx_err = '0;
    logic done, raw_ovf, err_groups, err_hist;
    logic [7:0] init_char, chk_byte, guard_n, wwt;
    logic [15:0] ifc_mask;
    logic [127:0] ifc_bytes;
    logic [HMAX*8-1:0] hist_bytes;
    logic [3:0] hist_count, fi, di, proto;
    logic [RDEP*8-1:0] raw_bytes;
    logic [RCW-1:0] raw_count;

    atr_parser #(.HIST_MAX(HMAX), .RAW_DEPTH(RDEP), .ERR_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_err(rx_err), .done(done), .init_char(init_char),
        .ifc_mask(ifc_mask), .ifc_bytes(ifc_bytes), .hist_bytes(hist_bytes),
        .hist_count(hist_count), .chk_byte(chk_byte), .fi(fi), .di(di),
        .guard_n(guard_n), .proto(proto), .wwt(wwt), .raw_bytes(raw_bytes),
        .raw_count(raw_count), .raw_ovf(raw_ovf), .err_groups(err_groups),
        .err_hist(err_hist)
    );

    always #(CLK_P/2) clk = ~clk;

    int total = 0, bad = 0, done_hits = 0;
    logic last_done;
    logic [7:0] stream [0:63];
    int n;
    logic [15:0] e_mask;
    logic [127:0] e_ifc;
    logic [HMAX*8-1:0] e_hist;
    int e_hcnt;
    logic [7:0] e_chk;
    logic e_errh;

    always @(negedge clk) if (done) done_hits++;

    task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic [2:0] e);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_err = e;
        @(negedge clk);
        rx_valid = 1'b0; rx_err = '0;
        last_done = done;
    endtask

    task automatic do_restart();
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        done_hits = 0;
        n = 0; e_mask = '0; e_ifc = '0; e_hist = '0; e_hcnt = 0; e_chk = '0; e_errh = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        stream[n] = b; n++;
    endtask

    task automatic put_ifc(input int idx, input logic [7:0] b);
        e_ifc[idx*8 +: 8] = b; e_mask[idx] = 1'b1; push(b);
    endtask

    task automatic check_defaults(input string tag);
        check({tag, " R13 mask"}, ifc_mask, 0);
        check({tag, " R13 raw"}, raw_count, 0);
        check({tag, " R13 params"}, {fi, di, guard_n, proto, wwt}, {4'd1, 4'd1, 8'd0, 4'd0, 8'd10});
        check({tag, " R13 flags"}, {done, raw_ovf, err_groups, err_hist, init_char}, 0);
    endtask

    task automatic build_random();
        logic [3:0] pres, nxt, h;
        logic t1;
        int hc;
        t1 = 1'b0;
        push(($urandom % 2) ? 8'h3B : 8'h3F);
        pres = 4'($urandom % 16);
        h = 4'($urandom % 16);
        push({pres, h});
        for (int g = 0; g < 4; g++) begin
            if (pres == 4'd0) break;
            nxt = 4'd0;
            for (int l = 0; l < 4; l++) begin
                if (pres[l]) begin
                    if (l == 3) begin
                        logic [3:0] low;
                        nxt = (g == 3 || $urandom % 3 == 0) ? 4'd0 : 4'($urandom % 16);
                        low = (g == 0) ? 4'($urandom % 3) : 4'($urandom % 16);
                        if (g == 0) t1 = (low == 4'd1);
                        put_ifc(g*4 + l, {nxt, low});
                    end else begin
                        put_ifc(g*4 + l, 8'($urandom));
                    end
                end
            end
            pres = pres[3] ? nxt : 4'd0;
        end
        hc = (h > HMAX) ? HMAX : int'(h);
        e_errh = (h > HMAX);
        for (int i = 0; i < hc; i++) begin
            logic [7:0] hb;
            hb = 8'($urandom);
            e_hist[i*8 +: 8] = hb;
            push(hb);
        end
        e_hcnt = hc;
        if (t1) begin
            e_chk = 8'($urandom);
            push(e_chk);
        end
    endtask

    task automatic run_stream(input bit with_noise);
        for (int i = 0; i < n; i++) begin
            if (with_noise && ($urandom % 5 == 0))
                send(8'($urandom), 3'(1 + $urandom % 7));
            send(stream[i], 3'd0);
            if (i < n - 1) check("R7 early done", last_done, 1'b0);
        end
        check("R7 done at last byte", last_done, 1'b1);
    endtask

    task automatic check_result(input string tag);
        logic [RDEP*8-1:0] e_raw;
        int lim;
        logic [7:0] td1;
        e_raw = '0;
        lim = (n > RDEP) ? RDEP : n;
        for (int i = 0; i < lim; i++) e_raw[i*8 +: 8] = stream[i];
        send(8'h5C, 3'd0);
        send(8'hA7, 3'd0);
        check({tag, " R7 done once"}, done_hits, 1);
        check({tag, " R1 init"}, init_char, stream[0]);
        check({tag, " R2 mask"}, ifc_mask, e_mask);
        check({tag, " R3 slots"}, ifc_bytes, e_ifc);
        check({tag, " R5 hist"}, hist_bytes, e_hist);
        check({tag, " R5 hcount"}, hist_count, e_hcnt);
        check({tag, " R6 chk"}, chk_byte, e_chk);
        check({tag, " R12 clamp"}, err_hist, e_errh);
        td1 = e_ifc[3*8 +: 8];
        check({tag, " R8 params"}, {fi, di, guard_n, proto, wwt},
              {e_mask[0] ? e_ifc[7:4] : 4'd1, e_mask[0] ? e_ifc[3:0] : 4'd1,
               e_mask[2] ? e_ifc[23:16] : 8'd0, e_mask[3] ? td1[3:0] : 4'd0,
               e_mask[6] ? e_ifc[55:48] : 8'd10});
        check({tag, " R9 R10 raw count"}, raw_count, lim);
        check({tag, " R9 overflow"}, raw_ovf, (n > RDEP));
        check({tag, " R9 raw content"}, raw_bytes, e_raw);
        check({tag, " R11 no fault"}, err_groups, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_defaults("reset");

        // format byte zero: completes right after it
        do_restart();
        check_defaults("restart");
        push(8'h3B); push(8'h00);
        run_stream(1'b0);
        check_result("R4 empty");

        // T=1 with no historical bytes needs a check byte
        do_restart();
        push(8'h3B); push(8'h80); put_ifc(3, 8'h01);
        e_chk = 8'h5A; push(8'h5A);
        run_stream(1'b0);
        check_result("R6 t1");
        check("R6 proto", proto, 4'd1);

        // work wait time from group 2
        do_restart();
        push(8'h3F); push(8'h90); put_ifc(0, 8'h11); put_ifc(3, 8'h40); put_ifc(6, 8'h20);
        run_stream(1'b1);
        check_result("R8 wwt");
        check("R8 wwt value", wwt, 8'h20);

        // fifth group announced
        do_restart();
        send(8'h3B, 3'd0); send(8'h80, 3'd0);
        for (int i = 0; i < 4; i++) send(8'h80, 3'd0);
        send(8'h11, 3'd0);
        send(8'h22, 3'd0);
        check("R11 err_groups", err_groups, 1'b1);
        check("R11 no done", done_hits, 0);
        check("R11 ignored after fault", raw_count, 6);
        check("R11 mask", ifc_mask, 16'h8888);

        // error-flagged byte before anything else
        do_restart();
        send(8'h99, 3'd4);
        check("R10 err byte ignored", {raw_count, init_char}, 0);

        for (int k = 0; k < 40; k++) begin
            do_restart();
            build_random();
            run_stream(1'b1);
            check_result("rand");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule